// File: doc/BRIEF.md
# Parallel Flash Host Bus Front End

This block sits behind the pins of a parallel NOR-style flash memory and turns the asynchronous host bus into clean, clocked events. A fast system clock oversamples the active-low chip-enable, write-enable and output-enable pins, the address bus and the data bus. Every pin passes through a two-flop synchronizer. Chip-enable and write-enable then go through a glitch filter. From the filtered pins the block classifies the current bus state as one of five operations: standby, output disable, read, write or automatic standby.

A write window is the interval in which chip-enable and write-enable are both active. The address is taken when the window opens, at whichever strobe falls later. The data is taken when the window closes, at whichever strobe rises first. The pair is then handed to the command logic downstream as a one-cycle strobe. During a read the block raises a read request and the enable for the data bus drivers. An inactivity timer sets an automatic-standby flag when the bus has been quiet long enough. A busy signal from a running program or erase operation holds off low-power entry.

All timing thresholds are given in system-clock cycles. `GLITCH_CYC` (default 3) is the shortest strobe level change that is accepted. `IDLE_CYC` (default 60) is the number of quiet cycles before automatic standby.

Top module: `flash_bus_front`

## Requirements
- R1: After reset, busOp is standby (0), dataOe, readReq, cmdValid and autoStby are 0, and lowPower is 1 while chip-enable is high and busy is low.
- R2: busOp encodes the decoded bus state as 0 standby (chip-enable high), 1 output disable (chip-enable low, write-enable and output-enable high), 2 read, 3 write (chip-enable and write-enable low), and 4 automatic standby, which overrides the other codes while autoStby is 1.
- R3: readReq and dataOe are 1 only while chip-enable and output-enable are low and write-enable is high.
- R4: A write reports on cmdAddr the address present when the later of the two strobes fell.
- R5: A write reports on cmdData the data present when the earlier of the two strobes rose.
- R6: If output-enable is low at any time while both write strobes are active, the write is dropped and no cmdValid is produced.
- R7: While chip-enable is high, dataOe and readReq are 0 and busOp is 0, whatever the other pins are.
- R8: A level change on chip-enable or write-enable that lasts fewer than GLITCH_CYC samples neither starts nor ends a bus operation. A change lasting at least that long is accepted.
- R9: After IDLE_CYC cycles with no pin change, autoStby becomes 1. A read that is in progress keeps dataOe at 1.
- R10: While busy is 1, autoStby and lowPower stay 0. Once busy drops and the bus stays quiet, both return to 1.
- R11: Each accepted write produces exactly one cmdValid pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable pin, active low |
| weN | input | 1 | Write enable pin, active low |
| oeN | input | 1 | Output enable pin, active low |
| addrIn | input | AW | Address bus pins |
| dataIn | input | DW | Data bus pins (input side) |
| busy | input | 1 | Program or erase operation running |
| busOp | output | 3 | Decoded bus operation code |
| readReq | output | 1 | Read access requested |
| dataOe | output | 1 | Data bus driver enable |
| cmdValid | output | 1 | One-cycle strobe for a completed write |
| cmdAddr | output | AW | Latched write address |
| cmdData | output | DW | Latched write data |
| autoStby | output | 1 | Bus idle long enough for automatic standby |
| lowPower | output | 1 | Low-power state permitted |

## Verification
Faults in the write capture logic appear only at cmdValid, cmdAddr and cmdData, a few cycles after the write window closes. Examples are a window edge detected at the wrong strobe, a stale abort flag, or a misaligned delay line between the strobes and the buses. The bench therefore varies which strobe leads and which trails, and moves the buses between the two edges. A broken glitch filter either passes spurious commands and decode changes or loses real ones, and this is visible within GLITCH_CYC plus the synchronizer latency. Faults in the idle counter or the busy gating show up on autoStby and lowPower only after the IDLE_CYC window has run out. For that reason both sides of that window are sampled.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  typedef enum logic [2:0] {
    OP_STANDBY   = 3'd0,
    OP_OUT_DIS   = 3'd1,
    OP_READ      = 3'd2,
    OP_WRITE     = 3'd3,
    OP_AUTO_STBY = 3'd4
  } busOp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;   // write window just opened
    logic trackData;  // window open: follow the data bus
    logic emitCmd;    // window closed cleanly: publish command
  } ctrlStrb_t;
endpackage

// File: rtl/fbf_datapath.sv
module fbf_datapath
  import fbf_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16,
  parameter int GLITCH_CYC = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ceN,
  input  logic          weN,
  input  logic          oeN,
  input  logic [AW-1:0] addrIn,
  input  logic [DW-1:0] dataIn,
  input  ctrlStrb_t     strb,
  output logic          ceAct,
  output logic          weAct,
  output logic          oeAct,
  output logic          activity,
  output logic          cmdValid,
  output logic [AW-1:0] cmdAddr,
  output logic [DW-1:0] cmdData
);
  localparam int BW = AW + DW;
  localparam int CW = $clog2(GLITCH_CYC + 1);
  localparam int NF = 2; // filtered pins: ce, we

  // two-flop synchronizers, pins made active-high
  logic [2:0]    pinS1, pinS2, pinPrev;
  logic [BW-1:0] busS1, busS2, busPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinS1 <= '0; pinS2 <= '0; pinPrev <= '0;
      busS1 <= '0; busS2 <= '0; busPrev <= '0;
    end else begin
      pinS1 <= {~oeN, ~weN, ~ceN};
      pinS2 <= pinS1;
      pinPrev <= pinS2;
      busS1 <= {addrIn, dataIn};
      busS2 <= busS1;
      busPrev <= busS2;
    end
  end

  assign activity = (pinS2 != pinPrev) || (busS2 != busPrev);
  assign oeAct = pinS2[2];

  // glitch filters for the two write strobes
  logic [NF-1:0] fltQ;
  for (genvar g = 0; g < NF; g++) begin : gFilt
    logic [CW-1:0] runCnt;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        runCnt <= '0;
        fltQ[g] <= 1'b0;
      end else if (pinS2[g] == fltQ[g]) begin
        runCnt <= '0;
      end else if (runCnt == CW'(GLITCH_CYC - 1)) begin
        runCnt <= '0;
        fltQ[g] <= pinS2[g];
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end

    // R8: the filtered strobe only moves towards the synchronized level
    a_r8_filter_follows: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(fltQ[g]) |-> (fltQ[g] == $past(pinS2[g])));
  end

  assign ceAct = fltQ[0];
  assign weAct = fltQ[1];

  // bus delay line matching the filter latency
  logic [BW-1:0] dly [GLITCH_CYC+1];
  assign dly[0] = busS2;
  for (genvar s = 1; s <= GLITCH_CYC; s++) begin : gDly
    always_ff @(posedge clk) begin
      if (!rstN) dly[s] <= '0;
      else       dly[s] <= dly[s-1];
    end
  end

  logic [AW-1:0] addrQ;
  logic [DW-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0; dataQ <= '0;
      cmdValid <= 1'b0; cmdAddr <= '0; cmdData <= '0;
    end else begin
      if (strb.loadAddr)  addrQ <= dly[GLITCH_CYC][BW-1:DW];
      if (strb.trackData) dataQ <= dly[GLITCH_CYC][DW-1:0];
      cmdValid <= strb.emitCmd;
      if (strb.emitCmd) begin
        cmdAddr <= addrQ;
        cmdData <= dataQ;
      end
    end
  end

  // R11: command strobe is a single cycle
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);
endmodule

// File: rtl/fbf_ctrl.sv
module fbf_ctrl
  import fbf_pkg::*;
#(
  parameter int IDLE_CYC = 60
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ceAct,
  input  logic      weAct,
  input  logic      oeAct,
  input  logic      activity,
  input  logic      busy,
  output ctrlStrb_t strb,
  output logic      wrAborted,
  output busOp_t    busOp,
  output logic      readReq,
  output logic      dataOe,
  output logic      autoStby,
  output logic      lowPower
);
  localparam int IW = $clog2(IDLE_CYC + 1);

  logic pairAct, pairPrev, openEdge, closeEdge;
  logic inWrite, abortQ;
  logic [IW-1:0] idleCnt;

  assign pairAct   = ceAct & weAct;
  assign openEdge  = pairAct & ~pairPrev;
  assign closeEdge = ~pairAct & pairPrev;

  assign strb.loadAddr  = openEdge;
  assign strb.trackData = pairAct;
  assign strb.emitCmd   = closeEdge & ~abortQ;
  assign wrAborted      = inWrite & abortQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pairPrev <= 1'b0;
      inWrite  <= 1'b0;
      abortQ   <= 1'b0;
    end else begin
      pairPrev <= pairAct;
      if (openEdge)       inWrite <= 1'b1;
      else if (closeEdge) inWrite <= 1'b0;
      if (openEdge) abortQ <= oeAct;
      else if (pairAct & oeAct) abortQ <= 1'b1;
    end
  end

  // inactivity timer, held at zero while busy
  always_ff @(posedge clk) begin
    if (!rstN)                      idleCnt <= '0;
    else if (busy || activity)      idleCnt <= '0;
    else if (idleCnt != IW'(IDLE_CYC)) idleCnt <= idleCnt + 1'b1;
  end

  assign autoStby = (idleCnt == IW'(IDLE_CYC));

  logic   readNow;
  busOp_t decoded;
  assign readNow = ceAct & oeAct & ~weAct;

  always_comb begin
    if (!ceAct)      decoded = OP_STANDBY;
    else if (weAct)  decoded = OP_WRITE;
    else if (oeAct)  decoded = OP_READ;
    else             decoded = OP_OUT_DIS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busOp    <= OP_STANDBY;
      readReq  <= 1'b0;
      dataOe   <= 1'b0;
      lowPower <= 1'b0;
    end else begin
      busOp    <= autoStby ? OP_AUTO_STBY : decoded;
      readReq  <= readNow;
      dataOe   <= readNow;
      lowPower <= (~ceAct | autoStby) & ~busy;
    end
  end

  // R10: automatic standby never starts out of a busy cycle
  a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    $rose(autoStby) |-> !$past(busy));
  // R10: low power never granted while busy was set
  a_r10_no_lp_busy: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> !lowPower);
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
  import fbf_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16,
  parameter int GLITCH_CYC = 3,
  parameter int IDLE_CYC = 60
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ceN,
  input  logic          weN,
  input  logic          oeN,
  input  logic [AW-1:0] addrIn,
  input  logic [DW-1:0] dataIn,
  input  logic          busy,
  output logic [2:0]    busOp,
  output logic          readReq,
  output logic          dataOe,
  output logic          cmdValid,
  output logic [AW-1:0] cmdAddr,
  output logic [DW-1:0] cmdData,
  output logic          autoStby,
  output logic          lowPower
);
  ctrlStrb_t strb;
  busOp_t    opQ;
  logic      ceAct, weAct, oeAct, activity, wrAborted;

  fbf_datapath #(.AW(AW), .DW(DW), .GLITCH_CYC(GLITCH_CYC)) i_dp (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addrIn(addrIn), .dataIn(dataIn), .strb(strb),
    .ceAct(ceAct), .weAct(weAct), .oeAct(oeAct), .activity(activity),
    .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdData(cmdData)
  );

  fbf_ctrl #(.IDLE_CYC(IDLE_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN), .ceAct(ceAct), .weAct(weAct), .oeAct(oeAct),
    .activity(activity), .busy(busy), .strb(strb), .wrAborted(wrAborted),
    .busOp(opQ), .readReq(readReq), .dataOe(dataOe),
    .autoStby(autoStby), .lowPower(lowPower)
  );

  assign busOp = opQ;

  // R6: an aborted write window never yields a command
  a_r6_abort_silent: assert property (@(posedge clk) disable iff (!rstN)
    wrAborted |=> !cmdValid);
  // R7: deselected chip never drives the data bus
  a_r7_standby_hiz: assert property (@(posedge clk) disable iff (!rstN)
    !ceAct |=> !dataOe);
  // R3: bus drive only when write strobe was inactive
  a_r3_no_drive_on_write: assert property (@(posedge clk) disable iff (!rstN)
    weAct |=> !dataOe);
endmodule

// File: tb/test_flash_bus_front.sv
`timescale 1ns/1ps
module test_flash_bus_front;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int GLITCH_CYC = 3;
  localparam int IDLE_CYC = 60;
  localparam real CLK_NS = 5.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1, busy = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [DW-1:0] dataIn = '0;
  logic [2:0] busOp;
  logic readReq, dataOe, cmdValid, autoStby, lowPower;
  logic [AW-1:0] cmdAddr;
  logic [DW-1:0] cmdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  flash_bus_front #(.AW(AW), .DW(DW), .GLITCH_CYC(GLITCH_CYC), .IDLE_CYC(IDLE_CYC)) i_flash_bus_front (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addrIn(addrIn), .dataIn(dataIn), .busy(busy),
    .busOp(busOp), .readReq(readReq), .dataOe(dataOe),
    .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .autoStby(autoStby), .lowPower(lowPower)
  );

  // command monitor, sampled on the falling edge
  int pulses = 0;
  int runLen = 0;
  int maxRun = 0;
  logic [AW-1:0] lastAddr = '0;
  logic [DW-1:0] lastData = '0;
  always @(negedge clk) begin
    if (rstN && cmdValid) begin
      if (runLen == 0) pulses++;
      runLen++;
      if (runLen > maxRun) maxRun = runLen;
      lastAddr = cmdAddr;
      lastData = cmdData;
    end else begin
      runLen = 0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic toIdle();
    ceN = 1; weN = 1; oeN = 1;
    waitCyc(15);
  endtask

  task automatic tReset();
    waitCyc(1);
    check(busOp == 3'd0, "R1 busOp", busOp, 0);
    check(dataOe == 0 && readReq == 0, "R1 drive", {dataOe, readReq}, 0);
    check(cmdValid == 0, "R1 cmdValid", cmdValid, 0);
    check(autoStby == 0, "R1 autoStby", autoStby, 0);
    waitCyc(4);
    check(lowPower == 1, "R1 lowPower", lowPower, 1);
  endtask

  task automatic tRead();
    ceN = 0; oeN = 0; weN = 1;
    waitCyc(12);
    check(busOp == 3'd2, "R2 read code", busOp, 2);
    check(dataOe == 1 && readReq == 1, "R3 read drive", {dataOe, readReq}, 3);
    oeN = 1;
    waitCyc(12);
    check(busOp == 3'd1, "R2 out-disable code", busOp, 1);
    check(dataOe == 0 && readReq == 0, "R3 out-disable hiz", {dataOe, readReq}, 0);
    toIdle();
  endtask

  task automatic tStandby();
    ceN = 1; oeN = 0; weN = 1;
    waitCyc(12);
    check(busOp == 3'd0, "R7 standby code", busOp, 0);
    check(dataOe == 0 && readReq == 0, "R7 standby hiz", {dataOe, readReq}, 0);
    toIdle();
  endtask

  // ce falls first, we falls later; we rises first
  task automatic tWriteWeLast();
    int p0 = pulses;
    addrIn = 21'h0AAAA; dataIn = 16'h1111;
    ceN = 0; waitCyc(8);
    addrIn = 21'h15555; waitCyc(8);
    weN = 0; waitCyc(8);
    addrIn = 21'h00123; dataIn = 16'hBEEF; waitCyc(8);
    weN = 1; waitCyc(8);
    dataIn = 16'h7777; waitCyc(8);
    ceN = 1; waitCyc(15);
    check(pulses == p0 + 1, "R11 one command", pulses, p0 + 1);
    check(maxRun == 1, "R11 pulse width", maxRun, 1);
    check(lastAddr == 21'h15555, "R4 addr at later fall", lastAddr, 21'h15555);
    check(lastData == 16'hBEEF, "R5 data at first rise", lastData, 16'hBEEF);
  endtask

  // we falls first, ce falls later; ce rises first
  task automatic tWriteCeLast();
    int p0 = pulses;
    addrIn = 21'h00F0F; dataIn = 16'h2222;
    weN = 0; waitCyc(8);
    addrIn = 21'h1C3C3; waitCyc(8);
    ceN = 0; waitCyc(8);
    addrIn = 21'h00001; dataIn = 16'h5A5A; waitCyc(8);
    ceN = 1; waitCyc(8);
    dataIn = 16'h9999; waitCyc(8);
    weN = 1; waitCyc(15);
    check(pulses == p0 + 1, "R4 second order count", pulses, p0 + 1);
    check(lastAddr == 21'h1C3C3, "R4 addr at ce fall", lastAddr, 21'h1C3C3);
    check(lastData == 16'h5A5A, "R5 data at ce rise", lastData, 16'h5A5A);
  endtask

  task automatic tAbort();
    int p0 = pulses;
    addrIn = 21'h00777; dataIn = 16'h4444;
    ceN = 0; weN = 0; waitCyc(10);
    oeN = 0; waitCyc(4);
    oeN = 1; waitCyc(10);
    weN = 1; ceN = 1; waitCyc(15);
    check(pulses == p0, "R6 aborted write", pulses, p0);
  endtask

  task automatic tGlitch();
    int p0 = pulses;
    // short ce pulse with we held low
    weN = 0; oeN = 1; waitCyc(8);
    ceN = 0; waitCyc(2); ceN = 1;
    waitCyc(15);
    check(pulses == p0, "R8 ce glitch no write", pulses, p0);
    weN = 1; waitCyc(10);
    // short we pulse while selected
    ceN = 0; waitCyc(12);
    weN = 0; waitCyc(1); weN = 1;
    waitCyc(15);
    check(pulses == p0, "R8 we glitch no write", pulses, p0);
    check(busOp == 3'd1, "R8 decode unchanged", busOp, 1);
    // short ce-high pulse during a read must not break it
    oeN = 0; waitCyc(12);
    ceN = 1; waitCyc(2); ceN = 0;
    waitCyc(1);
    for (int i = 0; i < 10; i++) begin
      if (dataOe !== 1'b1) begin
        check(0, "R8 read held", dataOe, 1);
        break;
      end
      waitCyc(1);
    end
    oeN = 1; waitCyc(10);
    // long enough we pulse is accepted
    dataIn = 16'h0C0C; addrIn = 21'h00042;
    weN = 0; waitCyc(6); weN = 1;
    waitCyc(15);
    check(pulses == p0 + 1, "R8 long pulse accepted", pulses, p0 + 1);
    toIdle();
  endtask

  task automatic tAutoStby();
    ceN = 0; oeN = 0; weN = 1;
    waitCyc(30);
    check(autoStby == 0, "R9 not yet idle", autoStby, 0);
    waitCyc(45);
    check(autoStby == 1, "R9 idle flag", autoStby, 1);
    check(busOp == 3'd4, "R2 auto standby code", busOp, 4);
    check(dataOe == 1, "R9 read keeps driving", dataOe, 1);
    toIdle();
    check(autoStby == 0, "R9 activity clears", autoStby, 0);
  endtask

  task automatic tBusy();
    busy = 1;
    waitCyc(90);
    check(autoStby == 0, "R10 busy blocks auto", autoStby, 0);
    check(lowPower == 0, "R10 busy blocks lowPower", lowPower, 0);
    busy = 0;
    waitCyc(70);
    check(autoStby == 1, "R10 auto after busy", autoStby, 1);
    check(lowPower == 1, "R10 lowPower after busy", lowPower, 1);
  endtask

  initial begin
    waitCyc(5);
    rstN = 1;
    tReset();
    toIdle();
    tRead();
    tStandby();
    tWriteWeLast();
    tWriteCeLast();
    tAbort();
    tGlitch();
    tAutoStby();
    tBusy();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule